// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector with Spike Filter

This block sits at the front of a two-wire bus slave. A fast system clock oversamples the raw clock and data lines. Each line passes through a two-flop synchroniser and then a digital spike filter. The block then reports bus conditions as one-cycle pulses: Start, Stop, clock rising edge (with the data bit sampled at that edge) and clock falling edge. It also reports a bus-idle level that is set by a Stop and cleared by a Start.

The protocol logic behind this block asks for the data line to be pulled low through `drv_low_req`. The block passes that request to its open-drain enable `sda_pull_en` only while the filtered clock is low, and only after a programmable hold time has passed since the last clock fall. Because of this, the slave's own data output can never change while the clock is high, and it never moves inside the uncertain region just after a falling clock edge. Both the filter width and the hold time are parameters counted in system-clock cycles.

Top module: `tw_bus_frontend`

## Requirements
- R1: While and right after reset, `bus_idle` is 1, `sda_pull_en` is 0, and all four event pulses and `rx_bit` are 0.
- R2: A level on either raw line that lasts fewer than `FILT_CYC` consecutive clock edges has no effect on any output. A level that lasts `FILT_CYC` edges or more is accepted.
- R3: A fall of data while the clock stays high gives `start_pulse`. It is high for exactly one cycle: the cycle that follows edge k+FILT_CYC+2, where edge k is the first edge that samples the raw change.
- R4: A rise of data while the clock stays high gives `stop_pulse`. It is one cycle wide, with the same latency as R3.
- R5: A rise of the filtered clock gives a one-cycle `rise_pulse`. In that same cycle, `rx_bit` holds the filtered data level (1 = line high), and `rx_bit` keeps that value until the next rise.
- R6: A fall of the filtered clock gives a one-cycle `fall_pulse`, with the same latency as R3.
- R7: If both filtered lines change on the same sample, only the clock edge is reported. There is no Start or Stop, and `bus_idle` does not change.
- R8: `bus_idle` goes to 1 in the cycle after a Stop and to 0 in the cycle after a Start. No other event changes it.
- R9: Data changes while the clock is low produce no event pulse of any kind.
- R10: If `fall_pulse` is high in cycle T, `sda_pull_en` keeps its value through cycle T+HOLD_CYC. It can first take the requested value in cycle T+HOLD_CYC+1.
- R11: `sda_pull_en` never changes between two samples while the filtered clock is high. A request that changes during the high phase waits for the hold window of the next fall.
- R12: Once the hold window has expired and the clock is low, `sda_pull_en` follows `drv_low_req` with one cycle of latency (1 = pull the data line low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| drv_low_req | input | 1 | Protocol logic asks to pull data low |
| start_pulse | output | 1 | One-cycle Start indication |
| stop_pulse | output | 1 | One-cycle Stop indication |
| rise_pulse | output | 1 | One-cycle clock rising-edge indication |
| fall_pulse | output | 1 | One-cycle clock falling-edge indication |
| rx_bit | output | 1 | Data level captured at the last clock rise |
| bus_idle | output | 1 | High from a Stop until the next Start |
| sda_pull_en | output | 1 | Open-drain pull-low enable for the data line |

## Verification
The bench sweeps glitch widths from one cycle up to the filter width on each line. A filter that is off by one would either let a too-short pulse through as a phantom Start/Stop or clock edge, or swallow a legal one. It checks the exact cycle of each event, so an extra pipeline stage or a missing one shows up directly. It sends every 8-bit value framed by Start and Stop, to catch a wrong data sampling point or events that appear between bits. It also makes both lines change together, toggles data while the clock is low, and changes the drive request while the clock is high. A design that reported Start/Stop for those cases, or released the data line early after a clock fall, would be caught by the counted event totals or by the recorded cycle of the enable change.

// File: rtl/twb_pkg.sv
// Shared types for the two-wire bus front end.
// Assumes: line index 0 is the bus clock, index 1 is the bus data line.
package twb_pkg;
    localparam int unsigned LINE_SCL  = 0;
    localparam int unsigned LINE_SDA  = 1;
    localparam int unsigned NUM_LINES = 2;

    // One-cycle bus condition flags produced by the detector.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;
endpackage

// File: rtl/twb_line_cond.sv
// Synchronises one raw bus line and removes spikes.
// The filtered level takes a new value only after the synchronised line
// has shown that value on FILT_CYC consecutive clock edges.
// Assumes: FILT_CYC >= 1; the idle bus level is high.
module twb_line_cond #(
    parameter int unsigned FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_sync,
    output logic line_flt
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          flt_q;

    // Two-flop synchroniser; reset to the idle (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_raw};
    end

    // Counts how long the synchronised level has differed from the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_q <= 1'b1;
            run_q <= '0;
        end else if (sync_q[1] == flt_q) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_CYC - 1)) begin
            flt_q <= sync_q[1];
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign line_sync = sync_q[1];
    assign line_flt  = flt_q;
endmodule

// File: rtl/twb_cond_detect.sv
// Turns the filtered clock and data levels into registered one-cycle
// condition pulses, the sampled data bit and the bus idle level.
// Assumes: the inputs are already synchronous and filtered. A change of
// both lines on the same sample counts as a clock edge only.
module twb_cond_detect
    import twb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_flt,
    input  logic     sda_flt,
    output bus_evt_t evt_q,
    output logic     rx_bit_q,
    output logic     idle_q,
    output logic     fall_now
);
    logic     scl_prev;
    logic     sda_prev;
    bus_evt_t evt_d;

    // Classify the current sample against the previous one.
    always_comb begin
        evt_d.rise  = scl_flt & ~scl_prev;
        evt_d.fall  = ~scl_flt & scl_prev;
        evt_d.start = scl_flt & scl_prev & sda_prev & ~sda_flt;
        evt_d.stop  = scl_flt & scl_prev & ~sda_prev & sda_flt;
    end

    assign fall_now = evt_d.fall;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_flt;
            sda_prev <= sda_flt;
        end
    end

    // Register the pulses and capture the data bit on a clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q    <= '0;
            rx_bit_q <= 1'b0;
        end else begin
            evt_q <= evt_d;
            if (evt_d.rise) rx_bit_q <= sda_flt;
        end
    end

    // Idle level: set by Stop, cleared by Start.
    always_ff @(posedge clk) begin
        if (!rst_n)           idle_q <= 1'b1;
        else if (evt_d.start) idle_q <= 1'b0;
        else if (evt_d.stop)  idle_q <= 1'b1;
    end
endmodule

// File: rtl/twb_out_hold.sv
// Gates the protocol's pull-low request onto the open-drain enable.
// The enable may only move while the filtered clock is low, and only once
// HOLD_CYC cycles have passed after the falling clock edge.
// Assumes: HOLD_CYC >= 1; fall_now is the combinational fall indication.
module twb_out_hold #(
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_flt,
    input  logic fall_now,
    input  logic drv_low_req,
    output logic pull_en
);
    localparam int unsigned TW = $clog2(HOLD_CYC + 2);

    logic [TW-1:0] tmr_q;
    logic          win_open;
    logic          pull_q;

    // Hold timer: reloaded on each clock fall, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            tmr_q <= '0;
        else if (fall_now)     tmr_q <= TW'(HOLD_CYC);
        else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
    end

    assign win_open = ~scl_flt & ~fall_now & (tmr_q == '0);

    // Update the enable only inside the open window.
    always_ff @(posedge clk) begin
        if (!rst_n)        pull_q <= 1'b0;
        else if (win_open) pull_q <= drv_low_req;
    end

    assign pull_en = pull_q;
endmodule

// File: rtl/tw_bus_frontend.sv
// Two-wire bus front end: per-line synchroniser and spike filter, condition
// detector, and a delayed open-drain output gate.
// Assumes: raw inputs are asynchronous levels; clk is much faster than the
// bus clock; FILT_CYC and HOLD_CYC are both at least 1.
module tw_bus_frontend
    import twb_pkg::*;
#(
    parameter int unsigned FILT_CYC = 3,
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic drv_low_req,
    output logic start_pulse,
    output logic stop_pulse,
    output logic rise_pulse,
    output logic fall_pulse,
    output logic rx_bit,
    output logic bus_idle,
    output logic sda_pull_en
);
    logic [NUM_LINES-1:0] raw_vec;
    logic [NUM_LINES-1:0] sync_vec;
    logic [NUM_LINES-1:0] flt_vec;
    logic                 scl_flt;
    logic                 sda_flt;
    logic                 sda_sync;
    logic                 fall_now;
    bus_evt_t             evt;

    assign raw_vec[LINE_SCL] = scl_in;
    assign raw_vec[LINE_SDA] = sda_in;

    // One conditioner per bus line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        twb_line_cond #(.FILT_CYC(FILT_CYC)) u_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_raw (raw_vec[g]),
            .line_sync(sync_vec[g]),
            .line_flt (flt_vec[g])
        );
    end

    assign scl_flt  = flt_vec[LINE_SCL];
    assign sda_flt  = flt_vec[LINE_SDA];
    assign sda_sync = sync_vec[LINE_SDA];

    twb_cond_detect u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_flt (scl_flt),
        .sda_flt (sda_flt),
        .evt_q   (evt),
        .rx_bit_q(rx_bit),
        .idle_q  (bus_idle),
        .fall_now(fall_now)
    );

    twb_out_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_flt    (scl_flt),
        .fall_now   (fall_now),
        .drv_low_req(drv_low_req),
        .pull_en    (sda_pull_en)
    );

    assign start_pulse = evt.start;
    assign stop_pulse  = evt.stop;
    assign rise_pulse  = evt.rise;
    assign fall_pulse  = evt.fall;
endmodule

// File: rtl/tw_bus_frontend_chk.sv
// Property checker for tw_bus_frontend, attached to it by bind.
// Assumes: it sees the filtered and synchronised internal levels of the top.
module tw_bus_frontend_chk #(
    parameter int unsigned HOLD_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic scl_flt,
    input logic sda_flt,
    input logic sda_sync,
    input logic start_pulse,
    input logic stop_pulse,
    input logic rise_pulse,
    input logic fall_pulse,
    input logic bus_idle,
    input logic sda_pull_en
);
    localparam int unsigned SW = $clog2(HOLD_CYC + 2);

    logic [SW-1:0] since_fall_q;
    logic [SW-1:0] since_fall;

    // Cycles since the last fall pulse, saturating just past the hold window.
    assign since_fall = fall_pulse ? '0 : since_fall_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                              since_fall_q <= SW'(HOLD_CYC + 1);
        else if (since_fall < SW'(HOLD_CYC + 1)) since_fall_q <= since_fall + 1'b1;
        else                                     since_fall_q <= SW'(HOLD_CYC + 1);
    end

    p_flt_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_flt) |-> (sda_flt == $past(sda_sync)));
    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    p_stop_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);
    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
    p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);
    p_idle_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> bus_idle);
    p_idle_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !bus_idle);
    p_hold_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_en) |-> (since_fall >= SW'(HOLD_CYC + 1)));
    p_hold_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        scl_flt |=> $stable(sda_pull_en));
endmodule

bind tw_bus_frontend tw_bus_frontend_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_flt    (scl_flt),
    .sda_flt    (sda_flt),
    .sda_sync   (sda_sync),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse),
    .bus_idle   (bus_idle),
    .sda_pull_en(sda_pull_en)
);

// File: tb/tw_bus_frontend_test.sv
// Self-checking bench for tw_bus_frontend: glitch-width sweeps, exact
// event latency, all 256 byte values, and output hold timing.
module tw_bus_frontend_test;
    localparam int  F      = 3;
    localparam int  H      = 4;
    localparam time CLK_PERIOD = 10ns;
    localparam int  S      = F + 4;
    localparam int  LAT    = F + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic req = 1'b0;
    logic start_p, stop_p, rise_p, fall_p, rx_bit, bus_idle, pull_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0;
    int t_start = -1, t_stop = -1, t_rise = -1, t_fall = -1, t_pen = -1;
    logic [7:0] shreg = '0;
    logic pen_prev = 1'b0;

    tw_bus_frontend #(.FILT_CYC(F), .HOLD_CYC(H)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .drv_low_req(req), .start_pulse(start_p), .stop_pulse(stop_p),
        .rise_pulse(rise_p), .fall_pulse(fall_p), .rx_bit(rx_bit),
        .bus_idle(bus_idle), .sda_pull_en(pull_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_p) begin n_start++; t_start = cyc; end
            if (stop_p)  begin n_stop++;  t_stop  = cyc; end
            if (rise_p)  begin n_rise++;  t_rise  = cyc; shreg = {shreg[6:0], rx_bit}; end
            if (fall_p)  begin n_fall++;  t_fall  = cyc; end
            if (pull_en !== pen_prev) t_pen = cyc;
        end
        pen_prev = pull_en;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        int c0, b0, b1, b2, b3;
        // R1: reset state
        tick(4);
        chk(bus_idle === 1'b1, "R1 idle", int'(bus_idle), 1);
        chk(pull_en === 1'b0, "R1 pull_en", int'(pull_en), 0);
        chk({start_p, stop_p, rise_p, fall_p, rx_bit} === 5'b0, "R1 pulses",
            int'({start_p, stop_p, rise_p, fall_p, rx_bit}), 0);
        rst_n = 1'b1;
        tick(10);
        chk({start_p, stop_p, rise_p, fall_p} === 4'b0 && bus_idle === 1'b1,
            "R1 after release", int'({bus_idle, start_p, stop_p, rise_p, fall_p}), 16);

        // R3: Start latency and width
        c0 = cyc; b0 = n_start;
        sda = 1'b0; tick(F + 8);
        chk(n_start == b0 + 1, "R3 start count", n_start - b0, 1);
        chk(t_start == c0 + LAT, "R3 start cycle", t_start, c0 + LAT);
        chk(bus_idle === 1'b0, "R8 idle cleared by start", int'(bus_idle), 0);
        // R4: Stop latency and width
        c0 = cyc; b0 = n_stop;
        sda = 1'b1; tick(F + 8);
        chk(n_stop == b0 + 1, "R4 stop count", n_stop - b0, 1);
        chk(t_stop == c0 + LAT, "R4 stop cycle", t_stop, c0 + LAT);
        chk(bus_idle === 1'b1, "R8 idle set by stop", int'(bus_idle), 1);

        // R2: glitch sweep on the data line with the clock high
        for (int w = 1; w <= F + 1; w++) begin
            b0 = n_start; b1 = n_stop;
            sda = 1'b0; tick(w); sda = 1'b1; tick(F + 8);
            if (w < F) begin
                chk(n_start == b0 && n_stop == b1 && bus_idle === 1'b1,
                    "R2 short data spike ignored", n_start - b0 + n_stop - b1, 0);
            end else begin
                chk(n_start == b0 + 1 && n_stop == b1 + 1,
                    "R2 long data pulse accepted", n_start - b0 + n_stop - b1, 2);
            end
        end
        // R2: glitch sweep on the clock line with data high
        for (int w = 1; w <= F + 1; w++) begin
            b0 = n_rise; b1 = n_fall; b2 = n_start; b3 = n_stop;
            scl = 1'b0; tick(w); scl = 1'b1; tick(F + 8);
            if (w < F) begin
                chk(n_rise == b0 && n_fall == b1, "R2 short clock spike ignored",
                    n_rise - b0 + n_fall - b1, 0);
            end else begin
                chk(n_rise == b0 + 1 && n_fall == b1 + 1, "R2 long clock pulse accepted",
                    n_rise - b0 + n_fall - b1, 2);
            end
            chk(n_start == b2 && n_stop == b3, "R2 clock pulse no condition",
                n_start - b2 + n_stop - b3, 0);
        end

        // R7: both lines change together
        b0 = n_fall; b1 = n_start; c0 = cyc;
        scl = 1'b0; sda = 1'b0; tick(F + 8);
        chk(n_fall == b0 + 1 && n_start == b1, "R7 joint fall is clock edge only",
            n_start - b1, 0);
        chk(t_fall == c0 + LAT, "R6 fall cycle", t_fall, c0 + LAT);
        b0 = n_rise; b1 = n_stop; c0 = cyc;
        scl = 1'b1; sda = 1'b1; tick(F + 8);
        chk(n_rise == b0 + 1 && n_stop == b1, "R7 joint rise is clock edge only",
            n_stop - b1, 0);
        chk(t_rise == c0 + LAT, "R5 rise cycle", t_rise, c0 + LAT);
        chk(rx_bit === 1'b1, "R5 rx_bit after joint rise", int'(rx_bit), 1);
        chk(bus_idle === 1'b1, "R7 idle unchanged", int'(bus_idle), 1);

        // R9: data toggles while clock low
        scl = 1'b0; tick(S);
        b0 = n_start + n_stop + n_rise + n_fall;
        for (int i = 0; i < 4; i++) begin
            sda = ~sda; tick(S);
        end
        chk(n_start + n_stop + n_rise + n_fall == b0, "R9 no event on low-clock data",
            n_start + n_stop + n_rise + n_fall - b0, 0);
        scl = 1'b1; tick(S);

        // R5/R6: every byte value framed by Start and Stop
        for (int b = 0; b < 256; b++) begin
            logic [7:0] v;
            v = 8'(b);
            b0 = n_start; b1 = n_stop; b2 = n_rise; b3 = n_fall;
            sda = 1'b0; tick(S);
            scl = 1'b0; tick(S);
            for (int i = 7; i >= 0; i--) begin
                sda = v[i]; tick(S);
                scl = 1'b1; tick(S);
                scl = 1'b0; tick(S);
            end
            chk(shreg == v, "R5 received byte", int'(shreg), b);
            chk(n_rise - b2 == 8 && n_fall - b3 == 9, "R6 edge counts in byte",
                (n_rise - b2) * 100 + (n_fall - b3), 809);
            sda = 1'b0; tick(S);
            scl = 1'b1; tick(S);
            sda = 1'b1; tick(S);
            chk(n_start - b0 == 1 && n_stop - b1 == 1 && bus_idle === 1'b1,
                "R8 one start and one stop per frame",
                (n_start - b0) * 10 + (n_stop - b1), 11);
        end

        // R11: request raised while clock high is deferred
        req = 1'b1; tick(S + 4);
        chk(pull_en === 1'b0, "R11 deferred while high", int'(pull_en), 0);
        // R10: first change exactly HOLD+1 cycles after the fall pulse
        scl = 1'b0; tick(F + H + 10);
        chk(t_pen == t_fall + H + 1, "R10 release delay after fall", t_pen, t_fall + H + 1);
        chk(pull_en === 1'b1, "R10 pull applied", int'(pull_en), 1);
        // R11: toggles while high have no effect
        scl = 1'b1; tick(S);
        c0 = t_pen;
        for (int i = 0; i < 5; i++) begin
            req = ~req; tick(2);
        end
        req = 1'b0; tick(3);
        chk(pull_en === 1'b1 && t_pen == c0, "R11 stable while high", int'(pull_en), 1);
        scl = 1'b0; tick(F + H + 10);
        chk(t_pen == t_fall + H + 1, "R10 second delay", t_pen, t_fall + H + 1);
        chk(pull_en === 1'b0, "R10 released", int'(pull_en), 0);
        // R12: follows request with one cycle of latency in open window
        for (int i = 0; i < 4; i++) begin
            c0 = cyc;
            req = ~req; tick(3);
            chk(t_pen == c0 + 1 && pull_en === req, "R12 follow latency", t_pen, c0 + 1);
        end
        req = 1'b0; tick(3);
        scl = 1'b1; tick(S);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule